// File: doc/BRIEF.md
# Boundary-Scan Port with Upset Recovery

This block is a boundary-scan test access port (16-state controller, 5-bit instruction register, one-bit bypass data path) paired with a recovery sequencer. In a radiation environment a single flipped bit in the 4-bit state register can throw the controller into the instruction-update state. That latches whatever the instruction shift register holds. If that value is the external-test code, the device pins are turned into active drivers.

When a recovery is requested, either on demand or from a free-running period counter, the sequencer takes over the mode-select and data-in lines internally. It holds mode-select high for five clocks, which reaches the reset state from any state. It then walks the controller through an instruction scan that shifts in all ones (bypass) and returns to idle. A fault-injection port overwrites the state register for one clock so that any upset can be reproduced.

Top module: `tap_upset_guard`

## Requirements
- R1: While `trst_n` is low the port is in Reset (code 4'hF), `instr` is 5'b11111, `extest_active`, `rec_busy` and `tdo` are 0.
- R2: On each rising `tck` the state follows the effective mode-select (TMS) bit. Reset(F): 0 goes to Idle, 1 stays in Reset. Idle(C): 1 goes to SelDR. SelDR(7): 0 goes to CapDR, 1 goes to SelIR. SelIR(4): 0 goes to CapIR, 1 goes to Reset. CapDR(6)/CapIR(E): 0 goes to ShiftDR(2)/ShiftIR(A), 1 goes to Exit1DR(1)/Exit1IR(9). Shift: 1 goes to Exit1. Exit1: 0 goes to PauseDR(3)/PauseIR(B), 1 goes to UpdDR(5)/UpdIR(D). Pause: 1 goes to Exit2DR(0)/Exit2IR(8). Exit2: 0 goes to Shift, 1 goes to Update. Update: 0 goes to Idle, 1 goes to SelDR. Any bit value not listed keeps the current state.
- R3: A clock edge in CapIR loads the instruction shift register with 5'b00001, and each edge in ShiftIR shifts `tdi` into its MSB. A clock edge in CapDR clears the bypass bit, and each edge in ShiftDR loads `tdi` into it. `tdo` is the shift register LSB in ShiftIR, the bypass bit in ShiftDR, and 0 in all other states.
- R4: A clock edge in UpdIR copies the shift register to `instr`. A clock edge in Reset sets `instr` to 5'b11111 (bypass).
- R5: `extest_active` is 1 exactly when `instr` equals 5'b00000 and the state is not Reset.
- R6: Five consecutive edges with the effective mode-select bit high reach Reset from any of the 16 states.
- R7: Once a recovery starts, `rec_busy` is high for exactly 17 clocks, and the `tms`/`tdi` pins are ignored. The state is Reset after the 5th clock, with `extest_active` low. After the 17th clock the state is Idle, `instr` is 5'b11111 and `rec_busy` is low.
- R8: With `REC_PERIOD` nonzero, a recovery starts on the `REC_PERIOD`-th clock after reset release, and again on the `REC_PERIOD`-th idle clock after each recovery ends.
- R9: When `inj_en` is high at a clock edge, the state becomes `inj_state`, regardless of the mode-select bit.
- R10: A recovery request arriving while `rec_busy` is high is ignored and neither extends nor restarts the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low port reset |
| tms | input | 1 | Mode-select pin |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| rec_req | input | 1 | On-demand recovery request |
| inj_en | input | 1 | Fault injection strobe |
| inj_state | input | 4 | State code forced by injection |
| instr | output | IR_W | Latched instruction |
| tap_state | output | 4 | Current controller state code |
| extest_active | output | 1 | Pin drivers would be enabled |
| rec_busy | output | 1 | Recovery sequencer owns TMS/TDI |

## Verification
The hard case to reach is the hazard itself: the update state reached with an external-test code already waiting in the shift register, then left with the pins still driving. The bench sets this up by injecting ShiftIR and clocking in zeros. It then injects UpdIR directly, so the controller latches external-test without a legal path through Exit1IR. After that it starts a recovery with the pins held at the opposite levels, and fires a second request mid-sequence. It also forces each of the 16 codes in turn and confirms that five high mode-select clocks reach Reset from every one.

// File: rtl/tapg_pkg.sv
`timescale 1ns/1ps
package tapg_pkg;

    // Controller state codes; all 16 values are legal states so an upset
    // or an injected value always lands on a defined state.
    typedef enum logic [3:0] {
        ST_EXIT2_DR = 4'h0,
        ST_EXIT1_DR = 4'h1,
        ST_SHIFT_DR = 4'h2,
        ST_PAUSE_DR = 4'h3,
        ST_SEL_IR   = 4'h4,
        ST_UPD_DR   = 4'h5,
        ST_CAP_DR   = 4'h6,
        ST_SEL_DR   = 4'h7,
        ST_EXIT2_IR = 4'h8,
        ST_EXIT1_IR = 4'h9,
        ST_SHIFT_IR = 4'hA,
        ST_PAUSE_IR = 4'hB,
        ST_IDLE     = 4'hC,
        ST_UPD_IR   = 4'hD,
        ST_CAP_IR   = 4'hE,
        ST_RESET    = 4'hF
    } tap_state_e;

    localparam int STATE_W = 4;

    function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
        tap_state_e n;
        unique case (s)
            ST_RESET:    n = m ? ST_RESET    : ST_IDLE;
            ST_IDLE:     n = m ? ST_SEL_DR   : ST_IDLE;
            ST_SEL_DR:   n = m ? ST_SEL_IR   : ST_CAP_DR;
            ST_CAP_DR:   n = m ? ST_EXIT1_DR : ST_SHIFT_DR;
            ST_SHIFT_DR: n = m ? ST_EXIT1_DR : ST_SHIFT_DR;
            ST_EXIT1_DR: n = m ? ST_UPD_DR   : ST_PAUSE_DR;
            ST_PAUSE_DR: n = m ? ST_EXIT2_DR : ST_PAUSE_DR;
            ST_EXIT2_DR: n = m ? ST_UPD_DR   : ST_SHIFT_DR;
            ST_UPD_DR:   n = m ? ST_SEL_DR   : ST_IDLE;
            ST_SEL_IR:   n = m ? ST_RESET    : ST_CAP_IR;
            ST_CAP_IR:   n = m ? ST_EXIT1_IR : ST_SHIFT_IR;
            ST_SHIFT_IR: n = m ? ST_EXIT1_IR : ST_SHIFT_IR;
            ST_EXIT1_IR: n = m ? ST_UPD_IR   : ST_PAUSE_IR;
            ST_PAUSE_IR: n = m ? ST_EXIT2_IR : ST_PAUSE_IR;
            ST_EXIT2_IR: n = m ? ST_UPD_IR   : ST_SHIFT_IR;
            ST_UPD_IR:   n = m ? ST_SEL_DR   : ST_IDLE;
            default:     n = ST_RESET;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/tapg_fsm.sv
`timescale 1ns/1ps
module tapg_fsm
    import tapg_pkg::*;
(
    input  logic                tck,
    input  logic                trst_n,
    input  logic                tms_eff,
    input  logic                inj_en,
    input  logic [STATE_W-1:0]  inj_state,
    output tap_state_e          state
);

    tap_state_e state_nxt;

    // Next-state decode
    always_comb begin
        state_nxt = tap_next(state, tms_eff);
    end

    // State register; injection overrides the decoded transition
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            state <= ST_RESET;
        end else if (inj_en) begin
            state <= tap_state_e'(inj_state);
        end else begin
            state <= state_nxt;
        end
    end

endmodule

// File: rtl/tapg_ir.sv
`timescale 1ns/1ps
module tapg_ir
    import tapg_pkg::*;
#(
    parameter int IR_W = 5
) (
    input  logic            tck,
    input  logic            trst_n,
    input  tap_state_e      state,
    input  logic            tdi_eff,
    output logic [IR_W-1:0] instr,
    output logic            tdo
);

    localparam logic [IR_W-1:0] BYPASS_CODE  = '1;
    localparam logic [IR_W-1:0] CAPTURE_CODE = IR_W'(1);

    logic [IR_W-1:0] ir_sh;
    logic            byp_bit;

    // Instruction shift path
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            ir_sh <= CAPTURE_CODE;
        end else begin
            unique case (state)
                ST_CAP_IR:   ir_sh <= CAPTURE_CODE;
                ST_SHIFT_IR: ir_sh <= {tdi_eff, ir_sh[IR_W-1:1]};
                default:     ir_sh <= ir_sh;
            endcase
        end
    end

    // Latched instruction
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            instr <= BYPASS_CODE;
        end else begin
            unique case (state)
                ST_RESET:  instr <= BYPASS_CODE;
                ST_UPD_IR: instr <= ir_sh;
                default:   instr <= instr;
            endcase
        end
    end

    // One-bit bypass data register
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            byp_bit <= 1'b0;
        end else begin
            unique case (state)
                ST_CAP_DR:   byp_bit <= 1'b0;
                ST_SHIFT_DR: byp_bit <= tdi_eff;
                default:     byp_bit <= byp_bit;
            endcase
        end
    end

    // Serial output selection
    always_comb begin
        unique case (state)
            ST_SHIFT_IR: tdo = ir_sh[0];
            ST_SHIFT_DR: tdo = byp_bit;
            default:     tdo = 1'b0;
        endcase
    end

endmodule

// File: rtl/tapg_recovery.sv
`timescale 1ns/1ps
module tapg_recovery #(
    parameter int IR_W         = 5,
    parameter int RESET_CYCLES = 5,
    parameter int REC_PERIOD   = 0
) (
    input  logic tck,
    input  logic trst_n,
    input  logic req,
    input  logic pin_tms,
    input  logic pin_tdi,
    output logic tms_eff,
    output logic tdi_eff,
    output logic busy
);

    // reset walk, then Idle, SelDR, SelIR, CapIR, ShiftIR, IR_W shifts,
    // Update and back to Idle
    localparam int SEQ_LEN = RESET_CYCLES + IR_W + 7;
    localparam int STEP_W  = $clog2(SEQ_LEN);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(SEQ_LEN - 1);

    logic [STEP_W-1:0] step;
    logic              per_tick;
    logic              start;

    function automatic logic seq_tms(input logic [STEP_W-1:0] s);
        int i;
        i = int'(s);
        if (i < RESET_CYCLES) return 1'b1;
        i = i - RESET_CYCLES;
        if (i == 1 || i == 2) return 1'b1;
        if (i == IR_W + 4 || i == IR_W + 5) return 1'b1;
        return 1'b0;
    endfunction

    generate
        if (REC_PERIOD > 0) begin : g_periodic
            localparam int PW = (REC_PERIOD > 1) ? $clog2(REC_PERIOD) : 1;
            localparam logic [PW-1:0] P_LAST = PW'(REC_PERIOD - 1);
            logic [PW-1:0] per_cnt;

            always_ff @(posedge tck or negedge trst_n) begin
                if (!trst_n) begin
                    per_cnt <= '0;
                end else if (!busy) begin
                    if (req || per_cnt == P_LAST) per_cnt <= '0;
                    else                         per_cnt <= per_cnt + 1'b1;
                end
            end
            assign per_tick = !busy && (per_cnt == P_LAST);
        end else begin : g_on_demand
            assign per_tick = 1'b0;
        end
    endgenerate

    assign start = !busy && (req || per_tick);

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            busy <= 1'b0;
            step <= '0;
        end else if (!busy) begin
            if (start) begin
                busy <= 1'b1;
                step <= '0;
            end
        end else begin
            if (step == LAST_STEP) busy <= 1'b0;
            step <= step + 1'b1;
        end
    end

    always_comb begin
        tms_eff = busy ? seq_tms(step) : pin_tms;
        tdi_eff = busy ? 1'b1 : pin_tdi;
    end

endmodule

// File: rtl/tap_upset_guard.sv
`timescale 1ns/1ps
module tap_upset_guard
    import tapg_pkg::*;
#(
    parameter int              IR_W         = 5,
    parameter int              RESET_CYCLES = 5,
    parameter int              REC_PERIOD   = 0,
    parameter logic [IR_W-1:0] EXTEST_CODE  = '0
) (
    input  logic                tck,
    input  logic                trst_n,
    input  logic                tms,
    input  logic                tdi,
    output logic                tdo,
    input  logic                rec_req,
    input  logic                inj_en,
    input  logic [STATE_W-1:0]  inj_state,
    output logic [IR_W-1:0]     instr,
    output logic [STATE_W-1:0]  tap_state,
    output logic                extest_active,
    output logic                rec_busy
);

    logic       tms_eff;
    logic       tdi_eff;
    tap_state_e state;

    tapg_recovery #(
        .IR_W         (IR_W),
        .RESET_CYCLES (RESET_CYCLES),
        .REC_PERIOD   (REC_PERIOD)
    ) u_rec (
        .tck     (tck),
        .trst_n  (trst_n),
        .req     (rec_req),
        .pin_tms (tms),
        .pin_tdi (tdi),
        .tms_eff (tms_eff),
        .tdi_eff (tdi_eff),
        .busy    (rec_busy)
    );

    tapg_fsm u_fsm (
        .tck       (tck),
        .trst_n    (trst_n),
        .tms_eff   (tms_eff),
        .inj_en    (inj_en),
        .inj_state (inj_state),
        .state     (state)
    );

    tapg_ir #(
        .IR_W (IR_W)
    ) u_ir (
        .tck     (tck),
        .trst_n  (trst_n),
        .state   (state),
        .tdi_eff (tdi_eff),
        .instr   (instr),
        .tdo     (tdo)
    );

    // Output process: flag drops on the same cycle Reset is entered
    always_comb begin
        tap_state     = state;
        extest_active = (instr == EXTEST_CODE) && (state != ST_RESET);
    end

endmodule

// File: rtl/tap_upset_guard_chk.sv
`timescale 1ns/1ps
module tap_upset_guard_chk #(
    parameter int IR_W         = 5,
    parameter int RESET_CYCLES = 5
) (
    input logic            tck,
    input logic            trst_n,
    input logic [3:0]      state,
    input logic            tms_eff,
    input logic            inj_en,
    input logic [3:0]      inj_state,
    input logic [IR_W-1:0] instr,
    input logic            extest_active,
    input logic            busy
);

    localparam int SEQ_LEN = RESET_CYCLES + IR_W + 7;

    int   busy_cnt;
    logic inj_seen;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            busy_cnt <= 0;
            inj_seen <= 1'b0;
        end else if (busy) begin
            busy_cnt <= busy_cnt + 1;
            inj_seen <= inj_seen | inj_en;
        end else begin
            busy_cnt <= 0;
            inj_seen <= 1'b0;
        end
    end

    p_reset_hold_r6: assert property (@(posedge tck) disable iff (!trst_n)
        (state == 4'hF && tms_eff && !inj_en) |=> (state == 4'hF));

    p_extest_off_r5: assert property (@(posedge tck) disable iff (!trst_n)
        (state == 4'hF) |-> !extest_active);

    p_bypass_load_r4: assert property (@(posedge tck) disable iff (!trst_n)
        (state == 4'hF) |=> (instr == '1));

    p_inject_r9: assert property (@(posedge tck) disable iff (!trst_n)
        inj_en |=> (state == $past(inj_state)));

    p_rec_reset_r7: assert property (@(posedge tck) disable iff (!trst_n)
        (busy && busy_cnt == RESET_CYCLES && !inj_seen) |-> (state == 4'hF && !extest_active));

    p_rec_len_r10: assert property (@(posedge tck) disable iff (!trst_n)
        busy |-> (busy_cnt < SEQ_LEN));

    p_rec_end_r7: assert property (@(posedge tck) disable iff (!trst_n)
        ($fell(busy) && !inj_seen) |-> (state == 4'hC && instr == '1));

endmodule

bind tap_upset_guard tap_upset_guard_chk #(
    .IR_W         (IR_W),
    .RESET_CYCLES (RESET_CYCLES)
) u_chk (
    .tck           (tck),
    .trst_n        (trst_n),
    .state         (tap_state),
    .tms_eff       (tms_eff),
    .inj_en        (inj_en),
    .inj_state     (inj_state),
    .instr         (instr),
    .extest_active (extest_active),
    .busy          (rec_busy)
);

// File: tb/tap_upset_guard_tb.sv
`timescale 1ns/1ps
module tap_upset_guard_tb;

    localparam int PER = 40;

    logic       tck = 1'b0;
    logic       trst_n = 1'b0;
    logic       tms = 1'b1;
    logic       tdi = 1'b0;
    logic       rec_req = 1'b0;
    logic       inj_en = 1'b0;
    logic [3:0] inj_state = 4'h0;

    logic       tdo, ext, busy;
    logic [4:0] instr;
    logic [3:0] st;
    logic       p_tdo, p_ext, p_busy;
    logic [4:0] p_instr;
    logic [3:0] p_st;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 tck = ~tck;

    tap_upset_guard u_dut (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
        .rec_req(rec_req), .inj_en(inj_en), .inj_state(inj_state),
        .instr(instr), .tap_state(st), .extest_active(ext), .rec_busy(busy)
    );

    tap_upset_guard #(.REC_PERIOD(PER)) u_per (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(p_tdo),
        .rec_req(1'b0), .inj_en(1'b0), .inj_state(4'h0),
        .instr(p_instr), .tap_state(p_st), .extest_active(p_ext), .rec_busy(p_busy)
    );

    // {tms, tdi, state[3:0], extest, tdo, instr[4:0]} after each clock
    localparam logic [12:0] VEC [35] = '{
        {1'b0,1'b0,4'hC,1'b0,1'b0,5'b11111},
        {1'b1,1'b0,4'h7,1'b0,1'b0,5'b11111},
        {1'b1,1'b0,4'h4,1'b0,1'b0,5'b11111},
        {1'b0,1'b0,4'hE,1'b0,1'b0,5'b11111},
        {1'b0,1'b0,4'hA,1'b0,1'b1,5'b11111},
        {1'b0,1'b0,4'hA,1'b0,1'b0,5'b11111},
        {1'b0,1'b0,4'hA,1'b0,1'b0,5'b11111},
        {1'b0,1'b0,4'hA,1'b0,1'b0,5'b11111},
        {1'b0,1'b0,4'hA,1'b0,1'b0,5'b11111},
        {1'b1,1'b0,4'h9,1'b0,1'b0,5'b11111},
        {1'b1,1'b0,4'hD,1'b0,1'b0,5'b11111},
        {1'b0,1'b0,4'hC,1'b1,1'b0,5'b00000},
        {1'b1,1'b0,4'h7,1'b1,1'b0,5'b00000},
        {1'b0,1'b0,4'h6,1'b1,1'b0,5'b00000},
        {1'b0,1'b0,4'h2,1'b1,1'b0,5'b00000},
        {1'b1,1'b1,4'h1,1'b1,1'b0,5'b00000},
        {1'b0,1'b0,4'h3,1'b1,1'b0,5'b00000},
        {1'b1,1'b0,4'h0,1'b1,1'b0,5'b00000},
        {1'b0,1'b0,4'h2,1'b1,1'b1,5'b00000},
        {1'b1,1'b0,4'h1,1'b1,1'b0,5'b00000},
        {1'b1,1'b0,4'h5,1'b1,1'b0,5'b00000},
        {1'b1,1'b0,4'h7,1'b1,1'b0,5'b00000},
        {1'b1,1'b0,4'h4,1'b1,1'b0,5'b00000},
        {1'b0,1'b0,4'hE,1'b1,1'b0,5'b00000},
        {1'b1,1'b0,4'h9,1'b1,1'b0,5'b00000},
        {1'b0,1'b0,4'hB,1'b1,1'b0,5'b00000},
        {1'b1,1'b0,4'h8,1'b1,1'b0,5'b00000},
        {1'b0,1'b1,4'hA,1'b1,1'b1,5'b00000},
        {1'b1,1'b1,4'h9,1'b1,1'b0,5'b00000},
        {1'b1,1'b0,4'hD,1'b1,1'b0,5'b00000},
        {1'b0,1'b0,4'hC,1'b0,1'b0,5'b10000},
        {1'b1,1'b0,4'h7,1'b0,1'b0,5'b10000},
        {1'b1,1'b0,4'h4,1'b0,1'b0,5'b10000},
        {1'b1,1'b0,4'hF,1'b0,1'b0,5'b10000},
        {1'b1,1'b0,4'hF,1'b0,1'b0,5'b11111}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge tck);
    endtask

    task automatic do_reset();
        trst_n = 1'b0;
        tms = 1'b1; tdi = 1'b0; rec_req = 1'b0; inj_en = 1'b0;
        step(); step();
        trst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int n;
        @(negedge tck);
        do_reset();
        // R1: reset values
        chk("R1 state", 32'(st), 32'hF);
        chk("R1 instr", 32'(instr), 32'h1F);
        chk("R1 extest", 32'(ext), 0);
        chk("R1 busy", 32'(busy), 0);
        chk("R1 tdo", 32'(tdo), 0);

        // R2/R3/R4/R5: vector walk through every state
        for (int i = 0; i < 35; i++) begin
            tms = VEC[i][12];
            tdi = VEC[i][11];
            step();
            chk($sformatf("R2 state v%0d", i), 32'(st), 32'(VEC[i][10:7]));
            chk($sformatf("R5 extest v%0d", i), 32'(ext), 32'(VEC[i][6]));
            chk($sformatf("R3 tdo v%0d", i), 32'(tdo), 32'(VEC[i][5]));
            chk($sformatf("R4 instr v%0d", i), 32'(instr), 32'(VEC[i][4:0]));
        end

        // R9 and R6: force every code, then five high clocks
        for (int s = 0; s < 16; s++) begin
            inj_en = 1'b1; inj_state = 4'(s); tms = 1'b0;
            step();
            chk($sformatf("R9 inject %0d", s), 32'(st), 32'(s));
            inj_en = 1'b0; tms = 1'b1;
            repeat (5) step();
            chk($sformatf("R6 walk from %0d", s), 32'(st), 32'hF);
        end

        // Hazard: zeros in shift register, then forced into UpdIR
        inj_en = 1'b1; inj_state = 4'hA; tms = 1'b0; tdi = 1'b0;
        step();
        inj_en = 1'b0;
        repeat (5) step();
        inj_en = 1'b1; inj_state = 4'hD;
        step();
        inj_en = 1'b0;
        step();
        chk("R4 forced latch", 32'(instr), 32'h00);
        chk("R5 extest set", 32'(ext), 1);

        // R7: recovery with pins held at opposite levels
        rec_req = 1'b1;
        step();
        rec_req = 1'b0;
        chk("R7 busy start", 32'(busy), 1);
        repeat (5) step();
        chk("R7 reset reached", 32'(st), 32'hF);
        chk("R7 extest cleared", 32'(ext), 0);
        step(); step();
        rec_req = 1'b1;   // R10: request while busy
        step();
        rec_req = 1'b0;
        repeat (8) step();
        chk("R7 in update", 32'(st), 32'hD);
        chk("R10 still busy", 32'(busy), 1);
        step();
        chk("R7 busy end", 32'(busy), 0);
        chk("R7 idle", 32'(st), 32'hC);
        chk("R7 bypass", 32'(instr), 32'h1F);
        step();
        chk("R10 no restart", 32'(busy), 0);
        chk("R10 pin resumes", 32'(st), 32'hC);

        // R8: periodic instance
        tms = 1'b0;
        do_reset();
        tms = 1'b0;
        n = 0;
        for (int k = 1; k <= 200; k++) begin
            step();
            if (p_busy) begin n = k; break; end
        end
        chk("R8 first period", 32'(n), 32'(PER));
        n = 0;
        for (int k = 1; k <= 200; k++) begin
            step();
            if (!p_busy) begin n = k; break; end
        end
        chk("R8 length", 32'(n), 17);
        chk("R8 end idle", 32'(p_st), 32'hC);
        n = 0;
        for (int k = 1; k <= 200; k++) begin
            step();
            if (p_busy) begin n = k; break; end
        end
        chk("R8 second period", 32'(n), 32'(PER));

        finish_run();
    end

endmodule